// File: doc/BRIEF.md
# Restart-Mode Pulse Width Capture Timer

This block measures the timing of an external digital signal with a 16-bit up-counter. Each qualified edge of the selected polarity copies the running count into a primary capture register, then clears the counter so that it starts again from zero. Each primary capture therefore reads directly as the spacing between consecutive qualified edges. An optional secondary capture register takes the count on the opposite edge. With a single edge polarity selected, this yields the width of one phase of the signal alongside the full period.

The input pin is asynchronous. It passes through a two-flop synchronizer and then a noise filter that samples on a separate sampling tick. A new level is accepted only when two consecutive samples agree. The counter advances on a count-clock tick. It runs only while the run bit is set. It raises a sticky overflow flag when it wraps.

Top module: `restart_capture_timer`

## Requirements
- R1: After reset, both capture outputs read 0, the edge pulse is low and the overflow flag is low.
- R2: With edgeSel = 2'b00 (rising edges valid) and a count tick on every clock, a rising edge P clocks after the previous one loads P-1 into capMain.
- R3: With edgeSel = 2'b01 (falling edges valid), capMain captures and restarts on falling edges. A period of P clocks reads P-1.
- R4: With edgeSel[1] = 1 (both edges valid), every accepted edge captures into capMain. capAlt never changes, even when capOppEn is 1.
- R5: With one polarity selected and capOppEn = 1, the opposite edge loads capAlt with the count since the last clear. That is the phase length minus 1. The counter is not cleared by this capture.
- R6: With capOppEn = 0, capAlt holds its value.
- R7: edgeIrq is a single-cycle pulse in the same cycle that capMain takes a new value. capMain changes at no other time.
- R8: A level that is not seen on two consecutive sampling ticks is rejected. While sampleEn is low, no edge is accepted.
- R9: The counter advances only on cntEn ticks. The clear replaces the first tick at or after the capture. With cntEn high every second clock and a 40-clock period, capMain reads 19.
- R10: A wrap from all-ones to zero sets ovfFlag. The flag stays set until ovfClr is pulsed, and a new wrap takes priority over the clear.
- R11: While runEn is low, the counter holds, edges cause no capture and edgeIrq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Count-clock tick enable |
| runEn | input | 1 | Run bit; low stops the counter and edge handling |
| pinIn | input | 1 | Asynchronous measured input |
| sampleEn | input | 1 | Sampling tick for the noise filter |
| edgeSel | input | 2 | 00 rising, 01 falling, 1x both edges valid |
| capOppEn | input | 1 | Enables secondary capture on the opposite edge |
| ovfClr | input | 1 | Clears the overflow flag |
| capMain | output | 16 | Primary capture register |
| capAlt | output | 16 | Secondary capture register |
| edgeIrq | output | 1 | One-cycle pulse per valid edge |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The checker watches several properties on every cycle. It checks that the edge pulse lasts a single cycle and that capMain changes only with that pulse. It checks that capAlt is frozen when secondary capture is off or both edges are selected. It checks that the overflow flag is sticky, that a stopped timer neither captures nor pulses, and that no pulse appears without an earlier sampling tick. Other behaviours can only be shown by bench scenarios driving real waveforms. These are the measured values (P-1 spacing, phase widths on the opposite edge, half-rate counting), glitch rejection, and the actual wrap after 65536 ticks.

// File: rtl/rct_pkg.sv
package rct_pkg;
  // Strobes from edge control to datapath
  typedef struct packed {
    logic capMain;  // load primary capture
    logic capAlt;   // load secondary capture
    logic clrReq;   // request counter restart
  } ctrlStrobe_t;
endpackage

// File: rtl/rct_edge_ctrl.sv
module rct_edge_ctrl
  import rct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pinIn,
  input  logic        sampleEn,
  input  logic        runEn,
  input  logic [1:0]  edgeSel,
  input  logic        capOppEn,
  output ctrlStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic syncOut, sampleHist, confLvl, riseDet, fallDet, agree;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) syncChain[0] <= 1'b0;
          else        syncChain[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) syncChain[i] <= 1'b0;
          else        syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncChain[LAST];
  // two consecutive samples see the same new level
  assign agree = sampleEn && (syncOut == sampleHist) && (syncOut != confLvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sampleHist <= 1'b0;
      confLvl    <= 1'b0;
      riseDet    <= 1'b0;
      fallDet    <= 1'b0;
    end else begin
      riseDet <= agree && syncOut;
      fallDet <= agree && !syncOut;
      if (sampleEn) sampleHist <= syncOut;
      if (agree)    confLvl    <= syncOut;
    end
  end

  logic bothSel, validEdge, oppEdge;
  always_comb begin
    bothSel   = edgeSel[1];
    validEdge = bothSel ? (riseDet || fallDet) : (edgeSel[0] ? fallDet : riseDet);
    oppEdge   = !bothSel && (edgeSel[0] ? riseDet : fallDet);
    strobe.capMain = runEn && validEdge;
    strobe.clrReq  = runEn && validEdge;
    strobe.capAlt  = runEn && capOppEn && oppEdge;
  end
endmodule

// File: rtl/rct_datapath.sv
module rct_datapath
  import rct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEn,
  input  logic             runEn,
  input  logic             ovfClr,
  input  ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] capMain,
  output logic [CNT_W-1:0] capAlt,
  output logic             edgeIrq,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;
  logic clrPend, pending, tick, wrap;

  assign pending = clrPend || strobe.clrReq;
  assign tick    = runEn && cntEn;
  assign wrap    = tick && !pending && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      clrPend <= 1'b0;
      capMain <= '0;
      capAlt  <= '0;
      edgeIrq <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      edgeIrq <= strobe.capMain;
      if (strobe.capMain) capMain <= count;
      if (strobe.capAlt)  capAlt  <= count;
      if (tick) begin
        count   <= pending ? '0 : count + 1'b1;
        clrPend <= 1'b0;
      end else if (strobe.clrReq) begin
        clrPend <= 1'b1;
      end
      if (wrap)        ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/restart_capture_timer.sv
module restart_capture_timer
  import rct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEn,
  input  logic             runEn,
  input  logic             pinIn,
  input  logic             sampleEn,
  input  logic [1:0]       edgeSel,
  input  logic             capOppEn,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] capMain,
  output logic [CNT_W-1:0] capAlt,
  output logic             edgeIrq,
  output logic             ovfFlag
);
  ctrlStrobe_t strobe;

  rct_edge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .sampleEn(sampleEn),
    .runEn(runEn), .edgeSel(edgeSel), .capOppEn(capOppEn), .strobe(strobe)
  );

  rct_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .runEn(runEn), .ovfClr(ovfClr),
    .strobe(strobe), .capMain(capMain), .capAlt(capAlt),
    .edgeIrq(edgeIrq), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             runEn,
  input logic             sampleEn,
  input logic [1:0]       edgeSel,
  input logic             capOppEn,
  input logic             ovfClr,
  input logic [CNT_W-1:0] capMain,
  input logic [CNT_W-1:0] capAlt,
  input logic             edgeIrq,
  input logic             ovfFlag
);
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edgeIrq |=> !edgeIrq);

  p_main_only_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !edgeIrq |-> $stable(capMain));

  p_alt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!capOppEn || edgeSel[1]) |=> $stable(capAlt));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  p_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> ($stable(capMain) && !edgeIrq));

  p_needs_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edgeIrq |-> $past(sampleEn, 2));
endmodule

bind restart_capture_timer rct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .runEn(runEn), .sampleEn(sampleEn),
  .edgeSel(edgeSel), .capOppEn(capOppEn), .ovfClr(ovfClr),
  .capMain(capMain), .capAlt(capAlt), .edgeIrq(edgeIrq), .ovfFlag(ovfFlag)
);

// File: tb/restart_capture_timer_bench.sv
module restart_capture_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cntEn = 1'b1, runEn = 1'b1, pinIn = 1'b0, sampleEn = 1'b1;
  logic [1:0] edgeSel = 2'b00;
  logic capOppEn = 1'b0, ovfClr = 1'b0;
  logic [15:0] capMain, capAlt;
  logic edgeIrq, ovfFlag;
  logic halfRate = 1'b0;
  int nChecks = 0, nFail = 0, irqCnt = 0;

  always #4 clk = ~clk;

  restart_capture_timer u_restart_capture_timer (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .runEn(runEn), .pinIn(pinIn),
    .sampleEn(sampleEn), .edgeSel(edgeSel), .capOppEn(capOppEn), .ovfClr(ovfClr),
    .capMain(capMain), .capAlt(capAlt), .edgeIrq(edgeIrq), .ovfFlag(ovfFlag)
  );

  always @(posedge clk) if (edgeIrq) irqCnt <= irqCnt + 1;
  always @(negedge clk) cntEn <= halfRate ? ~cntEn : 1'b1;

  // sel, opp, high, low, expMain, expAlt, expIrq
  localparam int VEC[4][7] = '{
    '{0, 1, 10, 14, 23,  9, 4},  // R2 R5
    '{1, 1, 10, 14, 23, 13, 4},  // R3 R5
    '{0, 0,  6, 30, 35, 13, 4},  // R2 R6
    '{2, 1,  8, 12,  7, 13, 8}   // R4
  };

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wave(int hi, int lo, int n);
    for (int k = 0; k < n; k++) begin
      pinIn = 1'b1; waitCyc(hi);
      pinIn = 1'b0; waitCyc(lo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int irq0;
    logic [15:0] held;
    waitCyc(3);
    // R1 reset state
    check("R1 capMain", capMain, 0);
    check("R1 capAlt", capAlt, 0);
    check("R1 edgeIrq", edgeIrq, 0);
    check("R1 ovfFlag", ovfFlag, 0);
    rst_n = 1'b1;
    waitCyc(5);

    for (int v = 0; v < 4; v++) begin
      edgeSel = VEC[v][0][1:0];
      capOppEn = VEC[v][1][0];
      waitCyc(4);
      irq0 = irqCnt;
      wave(VEC[v][2], VEC[v][3], 4);
      waitCyc(8);
      check($sformatf("R2/R3/R4 vec%0d capMain", v), capMain, VEC[v][4]);
      check($sformatf("R5/R6 vec%0d capAlt", v), capAlt, VEC[v][5]);
      check($sformatf("R7 vec%0d irq count", v), irqCnt - irq0, VEC[v][6]);
    end

    // R8 one-clock glitch rejected
    edgeSel = 2'b00; capOppEn = 1'b0; waitCyc(5);
    irq0 = irqCnt;
    pinIn = 1'b1; waitCyc(1); pinIn = 1'b0; waitCyc(10);
    check("R8 glitch rejected", irqCnt - irq0, 0);
    // R8 no sampling tick, no edge
    sampleEn = 1'b0;
    pinIn = 1'b1; waitCyc(10); pinIn = 1'b0; waitCyc(6);
    sampleEn = 1'b1; waitCyc(6);
    check("R8 sampleEn low", irqCnt - irq0, 0);
    // R8 two-clock level accepted
    pinIn = 1'b1; waitCyc(2); pinIn = 1'b0; waitCyc(10);
    check("R8 two-sample pulse", irqCnt - irq0, 1);

    // R11 stopped
    runEn = 1'b0; waitCyc(2);
    held = capMain; irq0 = irqCnt;
    wave(6, 6, 3);
    waitCyc(6);
    check("R11 no irq while stopped", irqCnt - irq0, 0);
    check("R11 capMain held", capMain, held);
    runEn = 1'b1; waitCyc(4);

    // R9 half-rate counting
    halfRate = 1'b1;
    wave(20, 20, 4);
    waitCyc(8);
    check("R9 half-rate capture", capMain, 19);
    halfRate = 1'b0; waitCyc(4);

    // R10 overflow
    ovfClr = 1'b1; waitCyc(1); ovfClr = 1'b0;
    check("R10 flag clear before wrap", ovfFlag, 0);
    waitCyc(65560);
    check("R10 flag set after wrap", ovfFlag, 1);
    waitCyc(20);
    check("R10 flag sticky", ovfFlag, 1);
    ovfClr = 1'b1; waitCyc(1); ovfClr = 1'b0; waitCyc(1);
    check("R10 flag cleared", ovfFlag, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule